// File: doc/BRIEF.md
# Resolution-Masked Temperature Capture Register

This block takes each finished temperature conversion, a 12-bit two's-complement word, and places it left-justified in a 16-bit register. Bits below the least significant bit of the selected resolution are cleared. The resolution can be 9, 10, 11 or 12 bits.

The block has two outputs, fed from the same masked word. The first is a compare path to the thermal alarm. It is loaded by every accepted sample and flagged by a one-cycle valid pulse. The second is the readable register seen by the serial interface. It is loaded only when the serial side is not reading at the moment the sample arrives. A sample that meets an ongoing read is dropped for the readable register. It is not queued. The readable register moves again at the next sample that arrives while no read is in progress.

The sample input is a valid/ready stream that never applies back-pressure. `smp_ready` rises one cycle after reset is released and stays high from then on. A sample is accepted in every cycle where `smp_valid` and `smp_ready` are both high. The compare output carries no ready. Its consumer must take `alm_value` in the cycle `alm_valid` is high. The read-busy flag and the resolution code are plain control inputs. Both are sampled in the same cycle as the accepted sample.

Top module: `tcap_top`

## Requirements
- R1: While reset is asserted and after it is released, `rd_temp`, `alm_value` and `alm_valid` are all zero until the first accepted sample.
- R2: The raw word occupies bits [15:4]: raw bit 11 lands on bit 15 (sign) and raw bit 10 on bit 14. Bits [3:0] of both outputs are always zero. With `res_sel`=2'b11 (12 bits, 0.0625 °C), all twelve raw bits are kept.
- R3: With `res_sel`=2'b00 (9 bits, 0.5 °C), bits [6:0] of the captured value are zero and bits [15:7] equal the raw bits [11:3].
- R4: With `res_sel`=2'b01 (10 bits, 0.25 °C), bits [5:0] are zero and bits [15:6] equal raw bits [11:2].
- R5: With `res_sel`=2'b10 (11 bits, 0.125 °C), bits [4:0] are zero and bits [15:5] equal raw bits [11:1].
- R6: Every accepted sample drives `alm_valid` high in the following cycle, with `alm_value` equal to the masked word, whatever the state of `rd_busy`.
- R7: A sample accepted while `rd_busy` is high leaves `rd_temp` unchanged.
- R8: A dropped sample is not remembered. After `rd_busy` falls, `rd_temp` keeps its old value until the next accepted sample, which then loads it one cycle later.
- R9: `smp_ready` is low in reset, high from the second cycle after reset release, and never falls again.
- R10: `alm_valid` is high for exactly one cycle per accepted sample and never without one.
- R11: The sign bit is preserved: bit 15 of the captured value equals raw bit 11 at every resolution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Conversion result valid |
| smp_ready | output | 1 | Sample input ready (high after reset) |
| smp_data | input | 12 | Raw two's-complement conversion result |
| res_sel | input | 2 | Resolution code: 00=9, 01=10, 10=11, 11=12 bits |
| rd_busy | input | 1 | Serial read in progress |
| rd_temp | output | 16 | Readable temperature register |
| alm_value | output | 16 | Masked compare value for the alarm |
| alm_valid | output | 1 | One-cycle pulse when alm_value is refreshed |

## Verification
The compare capture and the read-busy gate can act in the same cycle. A single accepted sample loads the alarm path and is refused by the readable register. The bench provokes this by presenting a sample with `rd_busy` high. It then judges, one cycle later, that `alm_value` carries the new masked word while `rd_temp` still holds the earlier one. Back-to-back samples with `rd_busy` toggled between them show that the readable register follows only the samples that arrive while `rd_busy` is low.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef enum logic [1:0] {
    RES_9  = 2'b00,
    RES_10 = 2'b01,
    RES_11 = 2'b10,
    RES_12 = 2'b11
  } tcap_res_e;

  // number of kept raw LSBs that are cleared for a given resolution code
  function automatic logic [1:0] drop_count(tcap_res_e r);
    case (r)
      RES_9:   drop_count = 2'd3;
      RES_10:  drop_count = 2'd2;
      RES_11:  drop_count = 2'd1;
      default: drop_count = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/tcap_mask.sv
module tcap_mask #(
  parameter int RAW_W = 12,
  parameter int REG_W = 16
) (
  input  logic [RAW_W-1:0] raw,
  input  logic [1:0]       res,
  output logic [REG_W-1:0] masked
);
  import tcap_pkg::*;

  localparam int PAD   = REG_W - RAW_W;
  localparam int LSB_W = $clog2(REG_W) + 1;

  logic [REG_W-1:0] ext;
  logic [LSB_W-1:0] keep_lsb;

  assign ext      = {raw, {PAD{1'b0}}};
  assign keep_lsb = LSB_W'(PAD) + LSB_W'(drop_count(tcap_res_e'(res)));

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (i < PAD) begin : g_pad
      assign masked[i] = 1'b0;
    end else begin : g_data
      assign masked[i] = (LSB_W'(i) >= keep_lsb) ? ext[i] : 1'b0;
    end
  end
endmodule

// File: rtl/tcap_cmp_stage.sv
module tcap_cmp_stage #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [REG_W-1:0] word,
  output logic [REG_W-1:0] value,
  output logic             valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
      valid <= 1'b0;
    end else begin
      valid <= take;
      if (take) value <= word;
    end
  end
endmodule

// File: rtl/tcap_read_reg.sv
module tcap_read_reg #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             busy,
  input  logic [REG_W-1:0] word,
  output logic [REG_W-1:0] value
);
  logic load;
  assign load = take && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= word;
  end
endmodule

// File: rtl/tcap_top.sv
module tcap_top #(
  parameter int RAW_W = 12,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [RAW_W-1:0] smp_data,
  input  logic [1:0]       res_sel,
  input  logic             rd_busy,
  output logic [REG_W-1:0] rd_temp,
  output logic [REG_W-1:0] alm_value,
  output logic             alm_valid
);
  logic             ready_q;
  logic             accept;
  logic [REG_W-1:0] word;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign smp_ready = ready_q;
  assign accept    = smp_valid && ready_q;

  tcap_mask #(.RAW_W(RAW_W), .REG_W(REG_W)) u_mask (
    .raw    (smp_data),
    .res    (res_sel),
    .masked (word)
  );

  tcap_cmp_stage #(.REG_W(REG_W)) u_cmp (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (accept),
    .word  (word),
    .value (alm_value),
    .valid (alm_valid)
  );

  tcap_read_reg #(.REG_W(REG_W)) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (accept),
    .busy  (rd_busy),
    .word  (word),
    .value (rd_temp)
  );
endmodule

// File: rtl/tcap_checker.sv
module tcap_checker #(
  parameter int RAW_W = 12,
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic [RAW_W-1:0] smp_data,
  input logic [1:0]       res_sel,
  input logic             rd_busy,
  input logic [REG_W-1:0] rd_temp,
  input logic [REG_W-1:0] alm_value,
  input logic             alm_valid
);
  logic acc;
  assign acc = smp_valid && smp_ready;

  AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_temp[3:0] == 4'h0) && (alm_value[3:0] == 4'h0)); // R2
  AST_RES9_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    acc && res_sel == 2'b00 |=> alm_value[6:0] == 7'h0); // R3
  AST_RES10_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    acc && res_sel == 2'b01 |=> alm_value[5:0] == 6'h0); // R4
  AST_RES11_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    acc && res_sel == 2'b10 |=> alm_value[4:0] == 5'h0); // R5
  AST_CMP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> alm_valid); // R6
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && rd_busy |=> $stable(rd_temp)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(rd_temp)); // R8
  AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> smp_ready); // R9
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    alm_valid |-> $past(acc)); // R10
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> alm_value[REG_W-1] == $past(smp_data[RAW_W-1])); // R11
endmodule

bind tcap_top tcap_checker #(.RAW_W(RAW_W), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .smp_data  (smp_data),
  .res_sel   (res_sel),
  .rd_busy   (rd_busy),
  .rd_temp   (rd_temp),
  .alm_value (alm_value),
  .alm_valid (alm_valid)
);

// File: tb/sim_tcap_top.sv
`timescale 1ns/1ps
module sim_tcap_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [11:0] smp_data = '0;
  logic [1:0]  res_sel = 2'b00;
  logic        rd_busy = 1'b0;
  logic [15:0] rd_temp;
  logic [15:0] alm_value;
  logic        alm_valid;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tcap_top u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .res_sel(res_sel), .rd_busy(rd_busy),
    .rd_temp(rd_temp), .alm_value(alm_value), .alm_valid(alm_valid)
  );

  function automatic logic [15:0] expect_word(logic [11:0] raw, logic [1:0] res);
    logic [15:0] v;
    logic [15:0] low;
    v   = {raw, 4'h0};
    low = (16'h1 << (7 - int'(res))) - 16'h1;
    return v & ~low;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present one sample; returns sampled after the capturing edge
  task automatic send(logic [11:0] raw, logic [1:0] res, logic busy);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = raw; res_sel = res; rd_busy = busy;
    @(negedge clk);
    smp_valid = 1'b0; rd_busy = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 rd_temp", rd_temp, 0);
    check("R1 alm_value", alm_value, 0);
    check("R1 alm_valid", alm_valid, 0);
    check("R9 ready in reset", smp_ready, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R9 ready after reset", smp_ready, 1);
    check("R1 rd_temp after release", rd_temp, 0);
    check("R1 alm_valid after release", alm_valid, 0);
  endtask

  task automatic t_resolutions;
    logic [11:0] pats [4] = '{12'h7D0, 12'hC91, 12'h32F, 12'hFFF};
    foreach (pats[p]) begin
      for (int r = 0; r < 4; r++) begin
        send(pats[p], 2'(r), 1'b0);
        check($sformatf("R%0d alm_value", (r == 3) ? 2 : r + 3), alm_value, expect_word(pats[p], 2'(r)));
        check("R6 alm_valid", alm_valid, 1);
        check("R2 rd_temp", rd_temp, expect_word(pats[p], 2'(r)));
        check("R11 sign", rd_temp[15], pats[p][11]);
      end
    end
    check("R3 explicit", expect_word(12'hC91, 2'b00), 16'hC900);
    check("R4 explicit", expect_word(12'h32F, 2'b01), 16'h32C0);
    check("R5 explicit", expect_word(12'h32F, 2'b10), 16'h32E0);
    @(negedge clk);
    check("R10 pulse ends", alm_valid, 0);
  endtask

  task automatic t_busy_skip;
    send(12'h190, 2'b11, 1'b0);
    check("R6 base", alm_value, 16'h1900);
    send(12'h1A3, 2'b11, 1'b1);
    check("R6 compare while busy", alm_value, 16'h1A30);
    check("R6 valid while busy", alm_valid, 1);
    check("R7 read held", rd_temp, 16'h1900);
    @(negedge clk); @(negedge clk);
    check("R8 not replayed", rd_temp, 16'h1900);
    check("R10 no pulse idle", alm_valid, 0);
    send(12'hE6F, 2'b01, 1'b0);
    check("R8 next update", rd_temp, 16'hE6C0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 12'h111; res_sel = 2'b11; rd_busy = 1'b0;
    @(negedge clk);
    check("R6 b2b first", alm_value, 16'h1110);
    smp_data = 12'h222; rd_busy = 1'b1;
    @(negedge clk);
    check("R7 b2b held", rd_temp, 16'h1110);
    check("R6 b2b second", alm_value, 16'h2220);
    check("R10 b2b valid", alm_valid, 1);
    smp_data = 12'h333; rd_busy = 1'b0;
    @(negedge clk);
    smp_valid = 1'b0;
    check("R8 b2b third", rd_temp, 16'h3330);
    @(negedge clk);
    check("R10 b2b end", alm_valid, 0);
    check("R9 ready kept", smp_ready, 1);
  endtask

  initial begin
    #20000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_resolutions();
    t_busy_skip();
    t_back_to_back();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule